// File: doc/BRIEF.md
# Programmable Interrupt Countdown Timer

This block counts down from a software-chosen initial value and requests an edge-triggered interrupt each time the count runs out. A tick input supplies the timebase. A prescaler thins those ticks by a programmable divide factor, so the main counter steps down only once for every D ticks. A configuration word sets both the interrupt vector and the mode. In periodic mode the timer reloads itself and keeps firing. In one-shot mode it fires once and then goes idle.

Writing a nonzero initial count starts the timer. Writing zero stops it. The current count can be read at any time. Each expiry produces a single-cycle request pulse, and the vector is presented on the same cycle. Some other block captures that pulse into an interrupt request register.

Top module: `intr_countdown_timer`

## Requirements
- R1: A prescaler counts accepted ticks modulo the divide factor D, where a D of 0 is treated as 1. The count decrements only on the tick that wraps the prescaler back to zero, which is once per D ticks. Every initial-count write clears the prescaler.
- R2: Bit 17 of `cfg_word` picks the mode: 1 selects periodic and 0 selects one-shot. During a pulse, `irq_vector` equals `cfg_word[7:0]` as it stood on the expiring tick.
- R3: In periodic mode, a decrement from a count of 1 fires a pulse. On that same edge the count reloads with the last written initial count, and the timer stays active.
- R4: In one-shot mode, a decrement from a count of 1 fires a pulse. The count then holds at 0, the timer becomes inactive, and it fires no further pulses however many ticks follow.
- R5: While the timer is inactive, ticks leave the count, the prescaler and `irq_pulse` untouched.
- R6: A write with a nonzero value loads that value into the count and activates the timer. A write of zero sets the count to 0 and deactivates the timer, so it never fires in either mode. A write takes precedence over a tick arriving in the same cycle.
- R7: `irq_pulse` is high for exactly the one cycle that follows the edge consuming the expiring tick. That is the same edge on which `cur_count` shows the reload or the zero.
- R8: After reset, `cur_count` is 0, `irq_pulse` is low and the timer is inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timebase tick, one per cycle at most |
| icount_wr | input | 1 | Initial-count write strobe |
| icount_data | input | CNT_W | Initial count value |
| cfg_word | input | 32 | Vector in [7:0], periodic mode in bit 17 |
| div_factor | input | DIV_W | Divide factor (0 behaves as 1) |
| cur_count | output | CNT_W | Current count readback |
| irq_pulse | output | 1 | One-cycle interrupt request |
| irq_vector | output | 8 | Vector of the request |

## Verification
Every result is registered once. A write or tick presented in one cycle therefore shows up on `cur_count`, `irq_pulse` and `irq_vector` right after the next rising edge. The bench drives inputs after a falling edge and advances a reference model on the rising edge. It then compares all outputs on the following falling edge, so each check sees the first cycle in which a result can be valid. Directed cases cover divide factors above one, zero writes, and ticks after a one-shot expiry, and seeded random traffic then mixes modes and divide factors.

// File: rtl/ltmr_pkg.sv
package ltmr_pkg;

    localparam int LTMR_VEC_W    = 8;
    localparam int LTMR_MODE_POS = 17;

    typedef enum logic {
        TM_ONESHOT  = 1'b0,
        TM_PERIODIC = 1'b1
    } tmr_mode_e;

    typedef struct packed {
        tmr_mode_e               mode;
        logic [LTMR_VEC_W-1:0]   vec;
    } tmr_cfg_t;

    function automatic tmr_cfg_t decode_cfg(input logic [31:0] word);
        tmr_cfg_t c;
        c.mode = tmr_mode_e'(word[LTMR_MODE_POS]);
        c.vec  = word[LTMR_VEC_W-1:0];
        return c;
    endfunction

endpackage

// File: rtl/ltmr_prescaler.sv
module ltmr_prescaler #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             adv,
    input  logic [DIV_W-1:0] div,
    output logic             strobe
);
    localparam logic [DIV_W:0] ONE = {{DIV_W{1'b0}}, 1'b1};

    logic [DIV_W-1:0] pre_q;
    logic [DIV_W:0]   inc;
    logic [DIV_W:0]   eff;
    logic             wrap;

    always_comb begin
        eff    = (div == '0) ? ONE : {1'b0, div};
        inc    = {1'b0, pre_q} + ONE;
        wrap   = (inc >= eff);
        strobe = adv && wrap;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            pre_q <= '0;
        end else if (adv) begin
            pre_q <= wrap ? '0 : inc[DIV_W-1:0];
        end
    end
endmodule

// File: rtl/ltmr_counter.sv
module ltmr_counter
    import ltmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  load,
    input  logic [CNT_W-1:0]      load_val,
    input  logic                  dec,
    input  tmr_cfg_t              cfg,
    output logic [CNT_W-1:0]      count,
    output logic [CNT_W-1:0]      reload,
    output logic                  active,
    output logic                  fire,
    output logic [LTMR_VEC_W-1:0] vec
);
    localparam logic [CNT_W-1:0] LAST = {{(CNT_W-1){1'b0}}, 1'b1};

    always_ff @(posedge clk) begin
        if (rst) begin
            count  <= '0;
            reload <= '0;
            active <= 1'b0;
            fire   <= 1'b0;
            vec    <= '0;
        end else begin
            fire <= 1'b0;
            if (load) begin
                count  <= load_val;
                reload <= load_val;
                active <= (load_val != '0);
            end else if (dec && active) begin
                if (count == LAST) begin
                    fire <= 1'b1;
                    vec  <= cfg.vec;
                    if (cfg.mode == TM_PERIODIC) begin
                        count <= reload;
                    end else begin
                        count  <= '0;
                        active <= 1'b0;
                    end
                end else begin
                    count <= count - LAST;
                end
            end
        end
    end
endmodule

// File: rtl/intr_countdown_timer.sv
module intr_countdown_timer
    import ltmr_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int DIV_W = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  tick,
    input  logic                  icount_wr,
    input  logic [CNT_W-1:0]      icount_data,
    input  logic [31:0]           cfg_word,
    input  logic [DIV_W-1:0]      div_factor,
    output logic [CNT_W-1:0]      cur_count,
    output logic                  irq_pulse,
    output logic [LTMR_VEC_W-1:0] irq_vector
);
    tmr_cfg_t         cfg;
    logic             active;
    logic             dec_stb;
    logic [CNT_W-1:0] init_q;

    assign cfg = decode_cfg(cfg_word);

    ltmr_prescaler #(.DIV_W(DIV_W)) u_pre (
        .clk    (clk),
        .rst    (rst),
        .clr    (icount_wr),
        .adv    (tick && active && !icount_wr),
        .div    (div_factor),
        .strobe (dec_stb)
    );

    ltmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (icount_wr),
        .load_val (icount_data),
        .dec      (dec_stb),
        .cfg      (cfg),
        .count    (cur_count),
        .reload   (init_q),
        .active   (active),
        .fire     (irq_pulse),
        .vec      (irq_vector)
    );
endmodule

// File: rtl/ltmr_checker.sv
module ltmr_checker #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             tick,
    input logic             icount_wr,
    input logic [CNT_W-1:0] icount_data,
    input logic [31:0]      cfg_word,
    input logic [CNT_W-1:0] cur_count,
    input logic             irq_pulse,
    input logic [7:0]       irq_vector,
    input logic [CNT_W-1:0] init_q
);
    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!tick && !icount_wr) |=> ($stable(cur_count) && !irq_pulse));

    // R6
    write_load_chk: assert property (@(posedge clk) disable iff (rst)
        icount_wr |=> (cur_count == $past(icount_data) && !irq_pulse));

    // R2
    vector_chk: assert property (@(posedge clk) disable iff (rst)
        irq_pulse |-> (irq_vector == $past(cfg_word[7:0])));

    // R4
    oneshot_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_pulse && !$past(cfg_word[17])) |-> (cur_count == '0));

    // R3
    periodic_reload_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_pulse && $past(cfg_word[17])) |-> (cur_count == init_q && init_q != '0));

    // R7
    pulse_needs_tick_chk: assert property (@(posedge clk) disable iff (rst)
        irq_pulse |-> ($past(tick) && $past(cur_count) == 1));
endmodule

bind intr_countdown_timer ltmr_checker #(.CNT_W(CNT_W)) u_ltmr_chk (
    .clk         (clk),
    .rst         (rst),
    .tick        (tick),
    .icount_wr   (icount_wr),
    .icount_data (icount_data),
    .cfg_word    (cfg_word),
    .cur_count   (cur_count),
    .irq_pulse   (irq_pulse),
    .irq_vector  (irq_vector),
    .init_q      (init_q)
);

// File: tb/tb_intr_countdown_timer.sv
`timescale 1ns/1ps
module tb_intr_countdown_timer;
    localparam int CNT_W = 32;
    localparam int DIV_W = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             tick = 1'b0;
    logic             icount_wr = 1'b0;
    logic [CNT_W-1:0] icount_data = '0;
    logic [31:0]      cfg_word = '0;
    logic [DIV_W-1:0] div_factor = 8'd1;
    logic [CNT_W-1:0] cur_count;
    logic             irq_pulse;
    logic [7:0]       irq_vector;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    longint m_cnt, m_init, m_pre;
    bit     m_act, m_irq;
    int     m_vec;

    always #5 clk = ~clk;

    intr_countdown_timer #(.CNT_W(CNT_W), .DIV_W(DIV_W)) dut (
        .clk(clk), .rst(rst), .tick(tick), .icount_wr(icount_wr),
        .icount_data(icount_data), .cfg_word(cfg_word), .div_factor(div_factor),
        .cur_count(cur_count), .irq_pulse(irq_pulse), .irq_vector(irq_vector)
    );

    function automatic int eff_div(input int d);
        return (d == 0) ? 1 : d;
    endfunction

    function automatic logic [31:0] mk_cfg(input bit periodic, input int vec);
        logic [31:0] w;
        w = {$urandom, 8'h00} ^ 32'h5a00_0000;
        w[17] = periodic;
        w[7:0] = vec[7:0];
        return w;
    endfunction

    task automatic model_edge();
        longint p;
        m_irq = 0;
        if (rst) begin
            m_cnt = 0; m_init = 0; m_pre = 0; m_act = 0; m_vec = 0;
        end else if (icount_wr) begin
            m_cnt = icount_data; m_init = icount_data; m_pre = 0;
            m_act = (icount_data != 0);
        end else if (tick && m_act) begin
            p = m_pre + 1;
            if (p >= eff_div(div_factor)) p = 0;
            m_pre = p;
            if (p == 0) begin
                if (m_cnt == 1) begin
                    m_irq = 1;
                    m_vec = cfg_word[7:0];
                    if (cfg_word[17]) m_cnt = m_init;
                    else begin m_cnt = 0; m_act = 0; end
                end else m_cnt = m_cnt - 1;
            end
        end
    endtask

    task automatic chk(input string tag, input string what, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic step(input string tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        chk(tag, "cur_count", cur_count, m_cnt);
        chk("R7", "irq_pulse", irq_pulse, m_irq);
        if (m_irq) chk("R2", "irq_vector", irq_vector, m_vec);
        tick = 0; icount_wr = 0;
    endtask

    task automatic wr(input longint v, input string tag);
        icount_wr = 1; icount_data = v[CNT_W-1:0];
        step(tag);
    endtask

    task automatic ticks(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            tick = 1;
            step(tag);
        end
    endtask

    task automatic finish_up();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(100000 * 10);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        void'($urandom(32'd1234));
        @(negedge clk);
        step("R8"); step("R8");
        rst = 0;
        step("R8");
        // R5: inactive timer ignores ticks
        ticks(5, "R5");
        // R3: periodic, divide 1, count 3
        cfg_word = mk_cfg(1, 8'h41); div_factor = 1;
        wr(3, "R6");
        ticks(7, "R3");
        // R1: divide by 3
        div_factor = 3;
        wr(2, "R1");
        ticks(8, "R1");
        // R1: divide factor 0 acts as 1
        div_factor = 0;
        wr(2, "R1");
        ticks(3, "R1");
        // R4: one-shot fires once then stays idle
        cfg_word = mk_cfg(0, 8'hc7); div_factor = 2;
        wr(2, "R6");
        ticks(12, "R4");
        // R6: zero write stops timer in periodic mode
        cfg_word = mk_cfg(1, 8'h12); div_factor = 1;
        wr(4, "R6");
        ticks(2, "R6");
        wr(0, "R6");
        ticks(6, "R6");
        // R6: write wins over a tick in the same cycle
        wr(1, "R6");
        tick = 1; icount_wr = 1; icount_data = 5;
        step("R6");
        ticks(6, "R3");
        // R7: count of 1 with divide 1 fires back-to-back pulses
        wr(1, "R7");
        ticks(4, "R7");
        // random traffic
        for (int i = 0; i < 4000; i++) begin
            tick = ($urandom_range(0, 3) != 0);
            if ($urandom_range(0, 40) == 0) begin
                icount_wr = 1;
                icount_data = $urandom_range(0, 6);
            end
            if ($urandom_range(0, 60) == 0)
                cfg_word = mk_cfg($urandom_range(0, 1), $urandom_range(0, 255));
            if ($urandom_range(0, 80) == 0)
                div_factor = $urandom_range(0, 4);
            step("R1");
        end
        finish_up();
    end
endmodule